// File: doc/BRIEF.md
# Butterfly Multiply-Accumulate with Round-Shift

This block is the arithmetic core of two integer butterfly operations used in fixed-point FFT and DCT kernels. It forms the signed product of two operands and keeps only the low word. It then either adds that word to an accumulator or subtracts it from the accumulator. When an immediate shift amount is non-zero, it adds a half-LSB rounding constant and shifts the sum right arithmetically.

The unit is purely combinational. The result follows the current inputs with no clock and no state. Register reads and writes, decode and any looping over vector elements belong to the surrounding pipeline. Data width and shift-field width are parameters: the default is 64-bit data with a 5-bit shift immediate. Any pair with 2^SW no larger than W is also valid.

Top module: `bfly_mac_rshift`

## Requirements
- R1: The product term is the low W bits of the signed product opA*opB and wraps modulo 2^W. For example, opA = all ones (-1) times opB = 5 gives 0xFFFF_FFFF_FFFF_FFFB.
- R2: With opSel = 0 (accumulate), the pre-shift sum is accIn plus the product term, modulo 2^W.
- R3: With opSel = 1 (subtract-from), the pre-shift sum is accIn minus the product term, modulo 2^W.
- R4: With shiftAmt = 0, result equals the pre-shift sum, and no rounding constant is added.
- R5: With shiftAmt = n > 0, the constant 2^(n-1) (only bit n-1 set, bit 0 = LSB) is added to the pre-shift sum, modulo 2^W, before the shift.
- R6: With shiftAmt = n > 0, the rounded sum is shifted right by n. The n vacated top bits are copied from bit W-1 of the rounded sum.
- R7: Every addition wraps and no saturation is applied. For example, accIn = 0x7FFF_FFFF_FFFF_FFFF with a zero product and n = 1 rounds to 0x8000_0000_0000_0000 and gives 0xC000_0000_0000_0000.
- R8: Fixed vectors:
  - accIn = 0x2aa17069, opA = 0xe6b8, opB = 0xd00, opSel = 0, shift 0 gives 0x3658c869.
  - The same operands with shift 14 give 0xd963.
  - accIn = 0xffffffffd90f96f9, opA = 0xe6b8, opB = 0xd00, opSel = 1, shift 0 gives 0xffffffffcd583ef9.
  - The same operands with shift 14 give 0xffffffffffff3561.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| accIn | input | W | Accumulator operand |
| opA | input | W | First multiplicand |
| opB | input | W | Second multiplicand |
| opSel | input | 1 | 0 = accumulate, 1 = subtract-from |
| shiftAmt | input | SW | Right-shift immediate; 0 disables rounding and shifting |
| result | output | W | Rounded, shifted result |

## Verification
A 4-bit-data, 2-bit-shift copy of the unit is swept over every combination of accumulator, operands, operation and shift. Each result is compared with an arithmetic model that uses floor division on a wide signed value. This sweep catches the following faults:
- a rounding bit placed one position off;
- rounding applied at shift zero;
- zero fill instead of sign fill;
- the sign taken from the unrounded sum, which fails when rounding carries into the top bit.

At full width, directed vectors cover three further faults:
- a product that does not wrap when the all-ones operand stands for -1;
- a sum that saturates at the positive limit;
- a swapped operation select.

A seeded pseudo-random sweep covers all 32 shift amounts.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  // Width of the rounding-position field carried from control to datapath.
  localparam int POS_W = 8;

  typedef enum logic {
    OP_ACC  = 1'b0,
    OP_SUBF = 1'b1
  } bflyOp_e;

  typedef struct packed {
    logic             doSub;     // subtract product instead of adding it
    logic             roundEn;   // non-zero shift: round and shift
    logic [POS_W-1:0] roundPos;  // bit index of the rounding constant (n-1)
  } bflyStrb_t;

endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import bfly_pkg::*;
#(
  parameter int SW = 5
) (
  input  logic          opSel,
  input  logic [SW-1:0] shiftAmt,
  output bflyStrb_t     strb
);

  bflyOp_e          opKind;
  logic [POS_W-1:0] amtWide;
  logic             nonZero;

  always_comb begin
    opKind        = bflyOp_e'(opSel);
    amtWide       = POS_W'(shiftAmt);
    nonZero       = (shiftAmt != '0);
    strb.doSub    = (opKind == OP_SUBF);
    strb.roundEn  = nonZero;
    strb.roundPos = nonZero ? (amtWide - POS_W'(1)) : '0;
  end

endmodule

// File: rtl/bfly_datapath.sv
module bfly_datapath
  import bfly_pkg::*;
#(
  parameter int W  = 64,
  parameter int SW = 5
) (
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  bflyStrb_t    strb,
  output logic [W-1:0] preShift,
  output logic [W-1:0] rounded,
  output logic [W-1:0] result
);

  // Low half of the product: identical for signed and unsigned operands.
  logic [W-1:0] prodLo;
  logic [W-1:0] addend;
  logic [W-1:0] roundVec;
  logic [SW-1:0] shAmt;
  logic          signBit;
  logic [W-1:0]  stg [SW+1];

  assign prodLo = opA * opB;

  // Subtraction as two's complement: invert the addend and carry in one.
  assign addend   = prodLo ^ {W{strb.doSub}};
  assign preShift = accIn + addend + W'(strb.doSub);

  // Rounding constant: one-hot at roundPos when enabled.
  for (genvar i = 0; i < W; i++) begin : g_rvec
    assign roundVec[i] = strb.roundEn && (strb.roundPos == POS_W'(i));
  end

  assign rounded = preShift + roundVec;
  assign signBit = rounded[W-1];

  // Shift amount recovered from the rounding position (n = pos + 1).
  assign shAmt = strb.roundEn ? (strb.roundPos[SW-1:0] + SW'(1)) : '0;

  // Log-stage arithmetic right shifter, sign filled.
  assign stg[0] = rounded;
  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = shAmt[k] ? {{STEP{signBit}}, stg[k][W-1:STEP]} : stg[k];
  end

  assign result = stg[SW];

endmodule

// File: rtl/bfly_mac_rshift.sv
module bfly_mac_rshift
  import bfly_pkg::*;
#(
  parameter int W  = 64,
  parameter int SW = 5
) (
  input  logic [W-1:0]  accIn,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic          opSel,
  input  logic [SW-1:0] shiftAmt,
  output logic [W-1:0]  result
);

  bflyStrb_t    strb;
  logic [W-1:0] preShift;
  logic [W-1:0] rounded;

  bfly_ctrl #(.SW(SW)) ctrlI (
    .opSel    (opSel),
    .shiftAmt (shiftAmt),
    .strb     (strb)
  );

  bfly_datapath #(.W(W), .SW(SW)) dpI (
    .accIn    (accIn),
    .opA      (opA),
    .opB      (opB),
    .strb     (strb),
    .preShift (preShift),
    .rounded  (rounded),
    .result   (result)
  );

endmodule

// File: rtl/bfly_mac_rshift_chk.sv
module bfly_mac_rshift_chk #(
  parameter int W  = 64,
  parameter int SW = 5
) (
  input logic [W-1:0]  accIn,
  input logic [W-1:0]  opA,
  input logic [W-1:0]  opB,
  input logic          opSel,
  input logic [SW-1:0] shiftAmt,
  input logic [W-1:0]  preShift,
  input logic [W-1:0]  rounded,
  input logic [W-1:0]  result
);

  logic [W-1:0]        prodChk;
  logic [W-1:0]        roundDiff;
  logic [W-1:0]        remLow;
  logic signed [W-1:0] hiPart;
  int                  shN;

  always_comb begin
    shN       = int'(shiftAmt);
    prodChk   = opA * opB;
    roundDiff = rounded - preShift;
    remLow    = rounded - (result << shN);
    hiPart    = $signed(result) >>> (W - 1 - shN);

    // R2
    sum_add_chk: assert (opSel || (preShift - accIn) == prodChk);
    // R3
    sum_sub_chk: assert (!opSel || (accIn - preShift) == prodChk);
    // R4
    pass_zero_chk: assert (shN != 0 || (result == preShift && roundDiff == '0));
    // R5
    round_bit_chk: assert (shN == 0 || roundDiff == (W'(1) << (shN - 1)));
    // R6
    sign_fill_chk: assert (hiPart == '0 || hiPart == '1);
    // R6
    trunc_rem_chk: assert (remLow < (W'(1) << shN));
    // R6
    sign_keep_chk: assert (shN == 0 || result[W-1] == rounded[W-1]);
  end

endmodule

bind bfly_mac_rshift bfly_mac_rshift_chk #(.W(W), .SW(SW)) chkI (
  .accIn    (accIn),
  .opA      (opA),
  .opB      (opB),
  .opSel    (opSel),
  .shiftAmt (shiftAmt),
  .preShift (preShift),
  .rounded  (rounded),
  .result   (result)
);

// File: tb/bfly_mac_rshift_test.sv
`timescale 1ns/1ps
module bfly_mac_rshift_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  // Full-width instance.
  logic [63:0] accW, aW, bW, resW;
  logic        opW;
  logic [4:0]  shW;

  bfly_mac_rshift uut (
    .accIn(accW), .opA(aW), .opB(bW), .opSel(opW), .shiftAmt(shW), .result(resW)
  );

  // Narrow instance for the exhaustive sweep.
  logic [3:0] accN, aN, bN, resN;
  logic       opN;
  logic [1:0] shN;

  bfly_mac_rshift #(.W(4), .SW(2)) uutNarrow (
    .accIn(accN), .opA(aN), .opB(bN), .opSel(opN), .shiftAmt(shN), .result(resN)
  );

  // Arithmetic model: wrap to w bits, add half LSB, floor-divide by 2^n.
  function automatic logic [63:0] mdl(input int w, input logic [63:0] acc,
                                      input logic [63:0] a, input logic [63:0] b,
                                      input logic op, input int n);
    logic [127:0] msk, p, s;
    logic signed [127:0] v;
    msk = (128'd1 << w) - 128'd1;
    p = ({64'd0, a} * {64'd0, b}) & msk;
    s = op ? (({64'd0, acc} - p) & msk) : (({64'd0, acc} + p) & msk);
    if (n != 0) s = (s + (128'd1 << (n - 1))) & msk;
    if (s[w-1]) v = $signed(s) - $signed(msk) - 128'sd1;
    else        v = $signed(s);
    v = v >>> n;
    return 64'(v & $signed(msk));
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic runWide(input string req, input logic [63:0] acc, input logic [63:0] a,
                         input logic [63:0] b, input logic op, input int n,
                         input logic [63:0] exp);
    @(negedge clk);
    accW = acc; aW = a; bW = b; opW = op; shW = 5'(n);
    #1;
    check(req, resW, exp);
  endtask

  initial begin
    logic [63:0] lfsr;
    accW = '0; aW = '0; bW = '0; opW = 1'b0; shW = '0;
    accN = '0; aN = '0; bN = '0; opN = 1'b0; shN = '0;
    @(negedge clk); #1;
    // R2 all-zero inputs give zero
    check("R2 idle", resW, 64'd0);
    check("R2 idle narrow", {60'd0, resN}, 64'd0);

    // R8 fixed vectors
    runWide("R8 acc s0", 64'h2aa17069, 64'he6b8, 64'hd00, 1'b0, 0, 64'h3658c869);
    runWide("R8 acc s14", 64'h2aa17069, 64'he6b8, 64'hd00, 1'b0, 14, 64'hd963);
    runWide("R8 sub s0", 64'hffffffffd90f96f9, 64'he6b8, 64'hd00, 1'b1, 0, 64'hffffffffcd583ef9);
    runWide("R8 sub s14", 64'hffffffffd90f96f9, 64'he6b8, 64'hd00, 1'b1, 14, 64'hffffffffffff3561);

    // R1 product wrap
    runWide("R1 neg1x5", 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 1'b0, 0, 64'hFFFF_FFFF_FFFF_FFFB);
    runWide("R1 min x2", 64'd7, 64'h8000_0000_0000_0000, 64'd2, 1'b0, 0, 64'd7);
    // R3 subtract a negative product
    runWide("R3 3-(-5)", 64'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 1'b1, 0, 64'd8);
    // R7 wrap without saturation
    runWide("R7 add wrap", 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'd1, 1'b0, 0, 64'h8000_0000_0000_0000);
    runWide("R7 round wrap", 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, 1'b0, 1, 64'hC000_0000_0000_0000);
    // R6 widest shift with sign fill
    runWide("R6 s31", 64'h8000_0000_0000_0000, 64'd0, 64'd0, 1'b0, 31, 64'hFFFF_FFFF_0000_0000);
    // R5 exact half rounds up
    runWide("R5 half", 64'd6, 64'd0, 64'd0, 1'b0, 2, 64'd2);
    runWide("R5 neg half", 64'hFFFF_FFFF_FFFF_FFFA, 64'd0, 64'd0, 1'b0, 2, 64'hFFFF_FFFF_FFFF_FFFF);

    // Exhaustive narrow sweep (R2..R6)
    for (int ac = 0; ac < 16; ac++)
      for (int ia = 0; ia < 16; ia++)
        for (int ib = 0; ib < 16; ib++)
          for (int op = 0; op < 2; op++)
            for (int n = 0; n < 4; n++) begin
              string tag;
              @(negedge clk);
              accN = 4'(ac); aN = 4'(ia); bN = 4'(ib); opN = op[0]; shN = 2'(n);
              #1;
              if (n == 0) tag = (op != 0) ? "R3 narrow" : "R2 narrow";
              else        tag = (resN[3]) ? "R6 narrow" : "R5 narrow";
              check(tag, {60'd0, resN},
                    mdl(4, 64'(ac), 64'(ia), 64'(ib), op[0], n));
            end

    // Pseudo-random full-width sweep over every shift (R4, R5, R6)
    lfsr = 64'h9E37_79B9_7F4A_7C15;
    for (int t = 0; t < 2048; t++) begin
      logic [63:0] ra, rb, rc;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      ra = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      rb = (t[0]) ? (lfsr >> 40) : lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      rc = lfsr;
      runWide((t % 32 == 0) ? "R4 random" : "R6 random", rc, ra, rb, t[5], t % 32,
              mdl(64, rc, ra, rb, t[5], t % 32));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule